// File: doc/BRIEF.md
# Page Program / Erase Sequencer

This block is the execution engine that sits behind a serial-flash command front-end. The front-end names a target address with `load_begin`, streams up to a page of data bytes into the block's internal page buffer, and then starts one of four array operations: program, page erase, page write or sector erase. The block then walks the external byte-wide array through a simple synchronous RAM port. The RAM returns read data one cycle after the address is presented. The block keeps `busy` high for a duration that stands in for the physical operation time.

A program operation can only clear bits. Each addressed byte becomes the AND of its old value and the buffered byte. A page write acts as an erase followed by a program on the addressed bytes only, so each of them ends up equal to the supplied data. Bytes of the page that were not sent are left untouched by both operations. A page erase fills a whole page with FFh. A sector erase fills a whole sector with FFh.

The control is one state machine with four states. IDLE waits for an accepted start and moves to SCAN. SCAN visits one byte offset per cycle. It moves to MERGE when a program operation reaches a buffered byte, since that byte needs the old value read back. It stays in SCAN while it advances to the next offset. It moves to HOLD after the last offset. MERGE writes the merged byte, then returns to SCAN, or moves to HOLD after the last offset. HOLD waits for the duration timer to expire and then returns to IDLE.

Top module: `pgseq_top`

## Requirements
- R1: After reset, `busy` and `mem_we` are low.
- R2: A one-cycle `go` pulse with `op` 0 (program), 1 (page erase), 2 (page write) or 3 (sector erase), given while idle, starts that operation, and `busy` is high from the next cycle. A `go` given while busy is ignored and does not restart or lengthen the operation.
- R3: A page erase sets all 256 bytes of the page selected by address bits [19:8] to FFh and leaves every other page unchanged.
- R4: A sector erase sets all 65536 bytes of the sector selected by address bits [19:16] to FFh, whatever the low 16 address bits are, and leaves other sectors unchanged.
- R5: A program operation turns each buffered byte's array location into old AND data. Page locations with no buffered byte keep their value.
- R6: A page write makes each buffered byte's array location equal to the data exactly. Page locations with no buffered byte keep their value.
- R7: `load_begin` sets the buffer start offset to address bits [7:0]. Each `load_valid` byte goes to the next offset, wrapping from 255 to 0 within the same page. When more than 256 bytes arrive, only the last 256 take effect.
- R8: A program or page write with no byte loaded since the last accepted `load_begin` is refused, and `busy` stays low.
- R9: With default parameters, `busy` stays high for exactly D+1 cycles. D is 400 for a page erase, 300+n for a program, 700+n for a page write and 70000 for a sector erase, where n is the number of bytes held (at most 256).
- R10: `load_begin` and `load_valid` are ignored while busy and in any cycle where `go` is high. When `load_begin` and `load_valid` come in the same cycle, that byte lands at the new start offset.
- R11: `mem_we` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_addr | input | ADDR_W (20) | Byte address captured on `load_begin` |
| load_begin | input | 1 | Start a new buffer fill at `cmd_addr` |
| load_valid | input | 1 | Data byte strobe |
| load_byte | input | 8 | Data byte |
| go | input | 1 | Start the operation selected by `op` |
| op | input | 2 | Operation code: 0 program, 1 page erase, 2 page write, 3 sector erase |
| busy | output | 1 | Operation in progress |
| mem_addr | output | ADDR_W (20) | Array byte address |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data for the address presented the cycle before |

## Verification
Two pairs of strobes can fall in the same cycle. In the first pair, `go` comes together with a `load_valid`. The bench raises both together and then repeats the same page write from the held buffer. It judges the run by the page contents and by the busy length, since a stray byte would change both. In the second pair, `load_begin` comes together with the first `load_valid`. The bench drives both in one cycle at offset 40h and checks that the byte lands at 40h and the next byte at 41h.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;

    typedef enum logic [1:0] {
        OP_PROG   = 2'd0,
        OP_PERASE = 2'd1,
        OP_PWRITE = 2'd2,
        OP_SERASE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_MERGE,
        ST_HOLD
    } st_e;

endpackage

// File: rtl/pgseq_buffer.sv
module pgseq_buffer #(
    parameter int PAGE_BYTES = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic [$clog2(PAGE_BYTES)-1:0] start_off,
    input  logic                          wr,
    input  logic [7:0]                    wdata,
    input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx,
    output logic [7:0]                    rd_data,
    output logic                          rd_mask,
    output logic [$clog2(PAGE_BYTES):0]   count
);
    localparam int PG_AW = $clog2(PAGE_BYTES);
    localparam int CNT_W = PG_AW + 1;

    logic [7:0]            store [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask;
    logic [PG_AW-1:0]      ptr;
    logic [PG_AW-1:0]      wptr;
    logic [PAGE_BYTES-1:0] mask_base;
    logic [CNT_W-1:0]      cnt_base;

    // A fresh fill restarts from the new offset in the same cycle
    always_comb begin
        wptr      = clr ? start_off : ptr;
        mask_base = clr ? '0 : mask;
        cnt_base  = clr ? '0 : count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask  <= '0;
            ptr   <= '0;
            count <= '0;
        end else if (clr || wr) begin
            ptr  <= wr ? wptr + 1'b1 : wptr;
            mask <= wr ? (mask_base | ({{(PAGE_BYTES-1){1'b0}}, 1'b1} << wptr)) : mask_base;
            if (wr && cnt_base != CNT_W'(PAGE_BYTES))
                count <= cnt_base + 1'b1;
            else
                count <= cnt_base;
        end
    end

    always_ff @(posedge clk) begin
        if (wr)
            store[wptr] <= wdata;
    end

    assign rd_data = store[rd_idx];
    assign rd_mask = mask[rd_idx];

    // R7: held byte count never exceeds one page
    a_r7_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(PAGE_BYTES));

endmodule

// File: rtl/pgseq_timer.sv
module pgseq_timer #(
    parameter int TMR_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [TMR_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R9: the duration is only loaded when no operation is running
    a_r9_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !load);

endmodule

// File: rtl/pgseq_ctrl.sv
module pgseq_ctrl
    import pgseq_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 65536,
    parameter int TMR_W        = 20,
    parameter int T_PERASE     = 400,
    parameter int T_SERASE     = 70000,
    parameter int T_PBASE      = 300,
    parameter int T_PBYTE      = 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            go,
    input  logic [1:0]                      op_in,
    input  logic [ADDR_W-1:0]               base_addr,
    input  logic [$clog2(PAGE_BYTES):0]     byte_cnt,
    input  logic [7:0]                      buf_byte,
    input  logic                            buf_mask,
    input  logic [7:0]                      mem_rdata,
    input  logic                            tmr_expired,
    output logic                            busy,
    output logic [$clog2(PAGE_BYTES)-1:0]   idx,
    output logic [ADDR_W-1:0]               mem_addr,
    output logic                            mem_we,
    output logic [7:0]                      mem_wdata,
    output logic                            tmr_load,
    output logic [TMR_W-1:0]                tmr_value
);
    localparam int PG_AW = $clog2(PAGE_BYTES);
    localparam int SC_AW = $clog2(SECTOR_BYTES);
    localparam logic [ADDR_W-1:0] PG_OFS = ADDR_W'(PAGE_BYTES - 1);
    localparam logic [ADDR_W-1:0] SC_OFS = ADDR_W'(SECTOR_BYTES - 1);

    st_e               st, st_n;
    op_e               op_q, op_sel;
    logic [ADDR_W-1:0] base_q;
    logic [SC_AW-1:0]  walk, walk_n;
    logic              accept, touch, at_end, erase_in;
    logic [TMR_W-1:0]  prog_t;

    always_comb begin
        op_sel   = op_e'(op_in);
        erase_in = (op_sel == OP_PERASE) || (op_sel == OP_SERASE);
        accept   = (st == ST_IDLE) && go && (erase_in || byte_cnt != '0);
        touch    = (op_q == OP_PERASE) || (op_q == OP_SERASE) || buf_mask;
        at_end   = (walk == ((op_q == OP_SERASE) ? SC_AW'(SECTOR_BYTES - 1)
                                                 : SC_AW'(PAGE_BYTES - 1)));
    end

    // Next-state and walk index
    always_comb begin
        st_n   = st;
        walk_n = walk;
        unique case (st)
            ST_IDLE: begin
                if (accept) begin
                    st_n   = ST_SCAN;
                    walk_n = '0;
                end
            end
            ST_SCAN: begin
                if (touch && op_q == OP_PROG) begin
                    st_n = ST_MERGE;
                end else if (at_end) begin
                    st_n = ST_HOLD;
                end else begin
                    walk_n = walk + 1'b1;
                end
            end
            ST_MERGE: begin
                if (at_end) begin
                    st_n = ST_HOLD;
                end else begin
                    st_n   = ST_SCAN;
                    walk_n = walk + 1'b1;
                end
            end
            ST_HOLD: begin
                if (tmr_expired)
                    st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            walk   <= '0;
            op_q   <= OP_PROG;
            base_q <= '0;
        end else begin
            st   <= st_n;
            walk <= walk_n;
            if (accept) begin
                op_q   <= op_sel;
                base_q <= base_addr & ~((op_sel == OP_SERASE) ? SC_OFS : PG_OFS);
            end
        end
    end

    // Outputs
    always_comb begin
        busy      = (st != ST_IDLE);
        idx       = walk[PG_AW-1:0];
        mem_addr  = base_q | ADDR_W'(walk);
        mem_we    = 1'b0;
        mem_wdata = 8'hFF;
        unique case (st)
            ST_SCAN: begin
                mem_we    = touch && (op_q != OP_PROG);
                mem_wdata = (op_q == OP_PWRITE) ? buf_byte : 8'hFF;
            end
            ST_MERGE: begin
                mem_we    = 1'b1;
                mem_wdata = mem_rdata & buf_byte;
            end
            default: ;
        endcase
    end

    // Duration loaded at the accepted start
    always_comb begin
        prog_t    = TMR_W'(T_PBASE) + TMR_W'(byte_cnt) * TMR_W'(T_PBYTE);
        tmr_load  = accept;
        tmr_value = prog_t;
        unique case (op_sel)
            OP_PROG:   tmr_value = prog_t;
            OP_PERASE: tmr_value = TMR_W'(T_PERASE);
            OP_PWRITE: tmr_value = TMR_W'(T_PERASE) + prog_t;
            OP_SERASE: tmr_value = TMR_W'(T_SERASE);
            default:   tmr_value = prog_t;
        endcase
    end

    // R5: a program write never raises a bit that the array held at 0
    a_r5_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && op_q == OP_PROG) |-> ((mem_wdata & ~mem_rdata) == 8'h00));

    // R3 / R4: erase writes are all ones
    a_r3_erase_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (op_q == OP_PERASE || op_q == OP_SERASE)) |-> (mem_wdata == 8'hFF));

endmodule

// File: rtl/pgseq_top.sv
module pgseq_top #(
    parameter int ADDR_W       = 20,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 65536,
    parameter int TMR_W        = 20,
    parameter int T_PERASE     = 400,
    parameter int T_SERASE     = 70000,
    parameter int T_PBASE      = 300,
    parameter int T_PBYTE      = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              load_begin,
    input  logic              load_valid,
    input  logic [7:0]        load_byte,
    input  logic              go,
    input  logic [1:0]        op,
    output logic              busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    localparam int PG_AW = $clog2(PAGE_BYTES);
    localparam int CNT_W = PG_AW + 1;

    logic              ld_ok, clr, wr;
    logic [ADDR_W-1:0] addr_q;
    logic [PG_AW-1:0]  idx;
    logic [7:0]        buf_byte;
    logic              buf_mask;
    logic [CNT_W-1:0]  byte_cnt;
    logic              tmr_load, tmr_expired;
    logic [TMR_W-1:0]  tmr_value;

    assign ld_ok = !busy && !go;
    assign clr   = load_begin && ld_ok;
    assign wr    = load_valid && ld_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else if (clr)
            addr_q <= cmd_addr;
    end

    pgseq_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .start_off (cmd_addr[PG_AW-1:0]),
        .wr        (wr),
        .wdata     (load_byte),
        .rd_idx    (idx),
        .rd_data   (buf_byte),
        .rd_mask   (buf_mask),
        .count     (byte_cnt)
    );

    pgseq_ctrl #(
        .ADDR_W       (ADDR_W),
        .PAGE_BYTES   (PAGE_BYTES),
        .SECTOR_BYTES (SECTOR_BYTES),
        .TMR_W        (TMR_W),
        .T_PERASE     (T_PERASE),
        .T_SERASE     (T_SERASE),
        .T_PBASE      (T_PBASE),
        .T_PBYTE      (T_PBYTE)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .op_in       (op),
        .base_addr   (addr_q),
        .byte_cnt    (byte_cnt),
        .buf_byte    (buf_byte),
        .buf_mask    (buf_mask),
        .mem_rdata   (mem_rdata),
        .tmr_expired (tmr_expired),
        .busy        (busy),
        .idx         (idx),
        .mem_addr    (mem_addr),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata),
        .tmr_load    (tmr_load),
        .tmr_value   (tmr_value)
    );

    pgseq_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_value),
        .run      (busy),
        .expired  (tmr_expired)
    );

    // R11: array writes only happen inside an operation
    a_r11_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R2: busy only rises after a start request
    a_r2_rise_after_go: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go));

endmodule

// File: tb/tb_pgseq_top.sv
module tb_pgseq_top;
    localparam int CLK_PERIOD = 10;
    localparam int T_PE = 400;
    localparam int T_SE = 70000;
    localparam int T_PB = 300;
    localparam int T_PY = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] cmd_addr = '0;
    logic        load_begin = 1'b0, load_valid = 1'b0, go = 1'b0;
    logic [7:0]  load_byte = '0;
    logic [1:0]  op = '0;
    logic        busy, mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'hFF;

    int checks = 0;
    int fails = 0;
    int stray_writes = 0;
    bit done = 1'b0;

    logic [7:0] arr  [int];
    logic [7:0] refm [int];
    logic [7:0] shadow [256];
    bit         smask  [256];
    int         sptr = 0;
    int         scount = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgseq_top dut (
        .clk(clk), .rst_n(rst_n), .cmd_addr(cmd_addr), .load_begin(load_begin),
        .load_valid(load_valid), .load_byte(load_byte), .go(go), .op(op),
        .busy(busy), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] rd_arr(int a);
        return arr.exists(a) ? arr[a] : 8'hFF;
    endfunction

    function automatic logic [7:0] rd_ref(int a);
        return refm.exists(a) ? refm[a] : 8'hFF;
    endfunction

    // Array model: erased at power-up, one-cycle read latency
    always @(posedge clk) begin
        mem_rdata <= rd_arr(int'(mem_addr));
        if (mem_we) arr[int'(mem_addr)] = mem_wdata;
    end

    // R11 monitor
    always @(negedge clk) if (rst_n && mem_we && !busy) stray_writes++;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic begin_load(int addr, bit with_byte, logic [7:0] b);
        @(negedge clk);
        cmd_addr = 20'(addr); load_begin = 1'b1;
        load_valid = with_byte; load_byte = b;
        for (int i = 0; i < 256; i++) smask[i] = 1'b0;
        sptr = addr & 255; scount = 0;
        if (with_byte) begin
            shadow[sptr] = b; smask[sptr] = 1'b1; sptr = (sptr + 1) & 255; scount = 1;
        end
        @(negedge clk);
        load_begin = 1'b0; load_valid = 1'b0;
    endtask

    task automatic send_bytes(int n, int seed);
        for (int i = 0; i < n; i++) begin
            load_valid = 1'b1; load_byte = 8'(seed + i * 37);
            shadow[sptr] = load_byte; smask[sptr] = 1'b1;
            sptr = (sptr + 1) & 255;
            if (scount < 256) scount++;
            @(negedge clk);
        end
        load_valid = 1'b0;
    endtask

    function automatic int duration(int o);
        case (o)
            0: return T_PB + scount * T_PY;
            1: return T_PE;
            2: return T_PE + T_PB + scount * T_PY;
            default: return T_SE;
        endcase
    endfunction

    task automatic apply_ref(int o, int addr);
        int pg = addr & ~255;
        int sc = addr & ~65535;
        case (o)
            0: for (int i = 0; i < 256; i++) if (smask[i]) refm[pg + i] = rd_ref(pg + i) & shadow[i];
            1: for (int i = 0; i < 256; i++) refm[pg + i] = 8'hFF;
            2: for (int i = 0; i < 256; i++) if (smask[i]) refm[pg + i] = shadow[i];
            default: for (int i = 0; i < 65536; i++) refm[sc + i] = 8'hFF;
        endcase
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    task automatic run_op(int o, int addr, string req);
        int n;
        int exp = duration(o);
        @(negedge clk);
        go = 1'b1; op = 2'(o);
        @(negedge clk);
        go = 1'b0;
        count_busy(n);
        check(n == exp + 1, req, "busy cycles", n, exp + 1);
        apply_ref(o, addr);
    endtask

    task automatic cmp_range(int base, int len, string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < len; i++)
            if (rd_arr(base + i) !== rd_ref(base + i)) begin
                bad++;
                if (first < 0) first = base + i;
            end
        if (first < 0) check(1'b1, req, "contents", 0, 0);
        else check(1'b0, req, $sformatf("byte @%0h", first), int'(rd_arr(first)), int'(rd_ref(first)));
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        check(mem_we == 1'b0, "R1", "mem_we after reset", int'(mem_we), 0);
    endtask

    task automatic t_page_write();
        begin_load(20'h00305, 1'b0, 8'h00);
        send_bytes(10, 8'h10);
        run_op(2, 20'h00305, "R9");
        cmp_range(20'h00300, 256, "R6");
    endtask

    task automatic t_program();
        begin_load(20'h00303, 1'b0, 8'h00);
        send_bytes(6, 8'h5A);
        run_op(0, 20'h00303, "R9");
        cmp_range(20'h00300, 256, "R5");
    endtask

    task automatic t_wrap();
        begin_load(20'h004FE, 1'b0, 8'h00);
        send_bytes(260, 8'h21);
        run_op(2, 20'h004FE, "R9");
        cmp_range(20'h00400, 256, "R7");
    endtask

    task automatic t_reject();
        begin_load(20'h00500, 1'b0, 8'h00);
        @(negedge clk); go = 1'b1; op = 2'd0;
        @(negedge clk); go = 1'b0;
        check(busy == 1'b0, "R8", "busy after empty program", int'(busy), 0);
        @(negedge clk); go = 1'b1; op = 2'd2;
        @(negedge clk); go = 1'b0;
        check(busy == 1'b0, "R8", "busy after empty page write", int'(busy), 0);
    endtask

    task automatic t_ignore();
        int n;
        begin_load(20'h00600, 1'b0, 8'h00);
        send_bytes(4, 8'hC3);
        // go and load_valid together: byte must be dropped (R10)
        @(negedge clk);
        go = 1'b1; op = 2'd2; load_valid = 1'b1; load_byte = 8'h00;
        @(negedge clk);
        go = 1'b0; load_valid = 1'b0;
        repeat (20) @(negedge clk);
        // strobes while busy: all ignored (R2, R10)
        go = 1'b1; op = 2'd1; load_valid = 1'b1; load_begin = 1'b1; cmd_addr = 20'h00700;
        @(negedge clk);
        go = 1'b0; load_valid = 1'b0; load_begin = 1'b0;
        count_busy(n);
        check(n + 21 == duration(2) + 1, "R2", "busy cycles with go while busy", n + 21, duration(2) + 1);
        apply_ref(2, 20'h00600);
        cmp_range(20'h00600, 256, "R2");
        // same buffer again: unchanged count and contents prove nothing was loaded
        run_op(2, 20'h00600, "R10");
        cmp_range(20'h00600, 256, "R10");
    endtask

    task automatic t_same_cycle();
        begin_load(20'h00740, 1'b1, 8'hA5);
        send_bytes(1, 8'h3C);
        run_op(2, 20'h00740, "R9");
        cmp_range(20'h00700, 256, "R10");
        check(rd_arr(20'h00740) == 8'hA5, "R10", "byte at start offset", int'(rd_arr(20'h00740)), 8'hA5);
    endtask

    task automatic t_page_erase();
        begin_load(20'h00377, 1'b0, 8'h00);
        run_op(1, 20'h00377, "R9");
        cmp_range(20'h00300, 256, "R3");
        cmp_range(20'h00400, 256, "R3");
    endtask

    task automatic t_sector();
        begin_load(20'h2ABCD, 1'b0, 8'h00);
        send_bytes(3, 8'h44);
        run_op(2, 20'h2ABCD, "R6");
        begin_load(20'h30000, 1'b0, 8'h00);
        send_bytes(1, 8'h12);
        run_op(2, 20'h30000, "R6");
        begin_load(20'h2F00F, 1'b0, 8'h00);
        run_op(3, 20'h2F00F, "R9");
        cmp_range(20'h20000, 65536, "R4");
        cmp_range(20'h30000, 256, "R4");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_page_write();
        t_program();
        t_wrap();
        t_reject();
        t_ignore();
        t_same_cycle();
        t_page_erase();
        t_sector();
        check(stray_writes == 0, "R11", "writes while idle", stray_writes, 0);
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

endmodule